// File: doc/BRIEF.md
# Overflow Interval Load Estimator

This block turns the spacing between overflow interrupts from a set of channel event counters into a coarse utilization figure for a frequency governor. It keeps one timestamp for each channel, taken from a free-running 64-bit nanosecond time base. When an overflow event arrives, the block works out which channel raised it and measures how long ago that channel last overflowed. A short interval means heavy traffic and gives a high busy figure. A long interval gives a low one. This produces a fast ramp up and a slow decay.

Each evaluation follows a fixed sequence. The block first requests that all counters stop. It then captures the time and the source channel, compares the interval and publishes a busy/total pair with a one-cycle `done` pulse. Finally it holds a restart request until the counter logic acknowledges that the counters have been cleared, preloaded and started again. Events that arrive during this sequence are queued and handled one at a time.

The FSM states are:
- ST_OFF: disabled.
- ST_IDLE: armed and waiting.
- ST_STOP: stop request.
- ST_EVAL: compare and publish.
- ST_RESTART: restart request held.

The transitions are:
- Any state goes to ST_OFF while `en` is low.
- ST_OFF goes to ST_IDLE when `en` is high. This loads both timestamps and the initial load.
- ST_IDLE goes to ST_STOP when the queue is non-empty. This takes one event.
- ST_STOP always goes to ST_EVAL. This captures the time and the channel.
- ST_EVAL always goes to ST_RESTART. This publishes the result and updates the chosen timestamp.
- ST_RESTART goes to ST_IDLE on `restart_ack`.

Top module: `ovf_load_est`

## Requirements
- R1: While reset is asserted, and after it is released until the block is enabled, `busy`, `total`, `done`, `ctr_stop` and `ctr_restart` are all 0.
- R2: At the first clock edge where `en` is high in ST_OFF, both channel timestamps take the value of `time_ns`, and the outputs become busy=99 and total=100 after that edge.
- R3: When the interval from the chosen channel's stored timestamp to the capture time is below 900,000,000 ns, the published pair is busy=70, total=100.
- R4: When that interval is 900,000,000 ns or more, the published pair is busy=35, total=100.
- R5: `ovf_flag[0]` is the flag of channel 0 and has priority. The last channel is chosen when every lower flag is clear, including when no flag is set. Only the chosen channel's timestamp is replaced by the capture time.
- R6: An event sampled at edge k makes `ctr_stop` high for exactly the cycle after edge k+1. The time and flags are captured at edge k+2, and the result and `done` appear after edge k+3. `ctr_restart` is high from then until the edge at which `restart_ack` is high.
- R7: Every clock cycle with `ovf_evt` high while armed is one event. Events that arrive during an evaluation are queued, up to 3 of them, and each is evaluated in turn. No new `ctr_stop` is issued while `ctr_restart` waits for its acknowledge.
- R8: Events while `en` is low have no effect. They raise no `ctr_stop` or `done`, and none is left queued when the block is enabled again.
- R9: The interval is the unsigned difference modulo 2^64, so it stays correct when `time_ns` wraps past zero.
- R10: `done` is high for exactly one cycle per evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Level enable; low disarms and clears the queue |
| time_ns | input | 64 | Free-running nanosecond time base |
| ovf_evt | input | 1 | Overflow interrupt, one event per high cycle |
| ovf_flag | input | 2 | Per-channel overflow flags, bit i is channel i |
| restart_ack | input | 1 | Counters cleared, preloaded and restarted |
| ctr_stop | output | 1 | One-cycle request to stop all counters |
| ctr_restart | output | 1 | Request to clear, preload and start counters, held until acknowledged |
| busy | output | 8 | Busy figure of the utilization pair |
| total | output | 8 | Total figure of the utilization pair |
| done | output | 1 | One-cycle pulse when a new pair is valid |

## Verification
Results are due at fixed distances from an event pulse driven before edge k:
- `ctr_stop` is high at the falling edge after k+1.
- `done`, `busy` and `total` are valid at the falling edge after k+3.
- `ctr_restart` drops at the falling edge after the acknowledging edge.
- The enable load is visible one falling edge after `en` is driven high.

The bench drives every input on a falling edge and samples at exactly these falling edges rather than waiting for a condition. A result that arrives one cycle early or late is therefore reported. The queue test stalls the acknowledge for several cycles and checks the second `ctr_stop` at its exact cycle after the acknowledge is given.

// File: rtl/ole_pkg.sv
package ole_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_STOP,
        ST_EVAL,
        ST_RESTART
    } ole_state_t;
endpackage

// File: rtl/ole_ts_bank.sv
module ole_ts_bank #(
    parameter int TS_W  = 64,
    parameter int NCH   = 2,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_all,
    input  logic [TS_W-1:0]  init_val,
    input  logic             load_one,
    input  logic [SEL_W-1:0] sel,
    input  logic [TS_W-1:0]  upd_val,
    output logic [TS_W-1:0]  ts_sel
);
    logic [TS_W-1:0] ts_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ts_q[g] <= '0;
            else if (load_all)
                ts_q[g] <= init_val;
            else if (load_one && (sel == SEL_W'(g)))
                ts_q[g] <= upd_val;
        end
    end

    assign ts_sel = ts_q[sel];
endmodule

// File: rtl/ole_interval.sv
module ole_interval #(
    parameter int TS_W = 64,
    parameter logic [TS_W-1:0] THRESH = 900_000_000
) (
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] last,
    output logic            is_short
);
    logic [TS_W-1:0] diff;

    // modulo 2^TS_W difference keeps a wrapped time base correct
    assign diff     = now - last;
    assign is_short = (diff < THRESH);
endmodule

// File: rtl/ole_pend.sv
module ole_pend #(
    parameter int PEND_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic nz
);
    logic [PEND_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != '1) cnt <= cnt + PEND_W'(1);
                2'b01:   cnt <= cnt - PEND_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign nz = (cnt != '0);
endmodule

// File: rtl/ovf_load_est.sv
module ovf_load_est
    import ole_pkg::*;
#(
    parameter int TS_W      = 64,
    parameter int NCH       = 2,
    parameter int LOAD_W    = 8,
    parameter int PEND_W    = 2,
    parameter logic [TS_W-1:0] THRESH = 900_000_000,
    parameter int BUSY_HI   = 70,
    parameter int BUSY_LO   = 35,
    parameter int BUSY_INIT = 99,
    parameter int TOTAL     = 100,
    localparam int SEL_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TS_W-1:0]   time_ns,
    input  logic              ovf_evt,
    input  logic [NCH-1:0]    ovf_flag,
    input  logic              restart_ack,
    output logic              ctr_stop,
    output logic              ctr_restart,
    output logic [LOAD_W-1:0] busy,
    output logic [LOAD_W-1:0] total,
    output logic              done
);
    ole_state_t state, state_nx;

    logic             pend_nz;
    logic             is_short;
    logic [SEL_W-1:0] sel_c, sel_q;
    logic [TS_W-1:0]  now_q;
    logic [TS_W-1:0]  ts_sel;
    logic             arm, take, eval;

    assign arm  = en && (state == ST_OFF);
    assign take = en && (state == ST_IDLE) && pend_nz;
    assign eval = en && (state == ST_EVAL);

    // lowest set flag wins; the last channel when all lower flags are clear
    always_comb begin
        sel_c = SEL_W'(NCH - 1);
        for (int i = NCH - 2; i >= 0; i--)
            if (ovf_flag[i]) sel_c = SEL_W'(i);
    end

    ole_pend #(.PEND_W(PEND_W)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .inc   (ovf_evt && en && (state != ST_OFF)),
        .dec   (take),
        .nz    (pend_nz)
    );

    ole_ts_bank #(.TS_W(TS_W), .NCH(NCH)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (arm),
        .init_val (time_ns),
        .load_one (eval),
        .sel      (sel_q),
        .upd_val  (now_q),
        .ts_sel   (ts_sel)
    );

    ole_interval #(.TS_W(TS_W), .THRESH(THRESH)) u_int (
        .now      (now_q),
        .last     (ts_sel),
        .is_short (is_short)
    );

    always_comb begin
        state_nx = state;
        if (!en)
            state_nx = ST_OFF;
        else begin
            unique case (state)
                ST_OFF:     state_nx = ST_IDLE;
                ST_IDLE:    if (pend_nz) state_nx = ST_STOP;
                ST_STOP:    state_nx = ST_EVAL;
                ST_EVAL:    state_nx = ST_RESTART;
                ST_RESTART: if (restart_ack) state_nx = ST_IDLE;
                default:    state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= '0;
            total <= '0;
            done  <= 1'b0;
            sel_q <= '0;
            now_q <= '0;
        end else begin
            done <= eval;
            if (en && (state == ST_STOP)) begin
                sel_q <= sel_c;
                now_q <= time_ns;
            end
            if (arm) begin
                busy  <= LOAD_W'(BUSY_INIT);
                total <= LOAD_W'(TOTAL);
            end else if (eval) begin
                busy  <= is_short ? LOAD_W'(BUSY_HI) : LOAD_W'(BUSY_LO);
                total <= LOAD_W'(TOTAL);
            end
        end
    end

    assign ctr_stop    = (state == ST_STOP);
    assign ctr_restart = (state == ST_RESTART);
endmodule

// File: rtl/ole_chk.sv
module ole_chk #(
    parameter int LOAD_W  = 8,
    parameter int BUSY_HI = 70,
    parameter int BUSY_LO = 35,
    parameter int TOTAL   = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              restart_ack,
    input logic              ctr_stop,
    input logic              ctr_restart,
    input logic [LOAD_W-1:0] busy,
    input logic [LOAD_W-1:0] total,
    input logic              done
);
    assert_stop_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_stop |=> !ctr_stop);

    assert_stop_to_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_stop && en) ##1 en |=> done);

    assert_restart_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_restart && !restart_ack && en) |=> ctr_restart);

    assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_restart && restart_ack) |=> !ctr_restart);

    assert_no_stop_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_restart |-> !ctr_stop);

    assert_no_stop_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ctr_stop && !done));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3 and R4: every published pair is one of the two fixed levels
    assert_pair_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((busy == LOAD_W'(BUSY_HI) || busy == LOAD_W'(BUSY_LO))
                  && total == LOAD_W'(TOTAL)));
endmodule

bind ovf_load_est ole_chk #(
    .LOAD_W  (LOAD_W),
    .BUSY_HI (BUSY_HI),
    .BUSY_LO (BUSY_LO),
    .TOTAL   (TOTAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .restart_ack (restart_ack),
    .ctr_stop    (ctr_stop),
    .ctr_restart (ctr_restart),
    .busy        (busy),
    .total       (total),
    .done        (done)
);

// File: tb/ovf_load_est_tb.sv
`timescale 1ns/1ps
module ovf_load_est_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [63:0] time_ns = '0;
    logic        ovf_evt = 1'b0;
    logic [1:0]  ovf_flag = '0;
    logic        restart_ack = 1'b0;
    logic        ctr_stop, ctr_restart, done;
    logic [7:0]  busy, total;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ovf_load_est u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .time_ns(time_ns),
        .ovf_evt(ovf_evt), .ovf_flag(ovf_flag), .restart_ack(restart_ack),
        .ctr_stop(ctr_stop), .ctr_restart(ctr_restart),
        .busy(busy), .total(total), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // fields: flags[73:72], time[71:8], expected busy[7:0]
    localparam logic [73:0] VEC [8] = '{
        {2'b01, 64'd1_500_000_000, 8'd70},
        {2'b10, 64'd1_800_000_000, 8'd70},
        {2'b11, 64'd2_400_000_000, 8'd35},
        {2'b00, 64'd2_699_999_999, 8'd70},
        {2'b10, 64'd3_500_000_000, 8'd70},
        {2'b01, 64'd3_500_000_000, 8'd35},
        {2'b01, 64'd3_500_000_001, 8'd70},
        {2'b10, 64'd4_399_999_999, 8'd70}
    };

    task automatic do_event(input logic [1:0] f, input logic [63:0] t,
                            input logic [7:0] exp_busy, input string tag);
        @(negedge clk); ovf_flag = f; time_ns = t; ovf_evt = 1'b1;
        @(negedge clk); ovf_evt = 1'b0;
        chk(ctr_stop == 1'b0, "R6 stop not early", ctr_stop, 0);
        @(negedge clk);
        chk(ctr_stop == 1'b1, "R6 stop cycle", ctr_stop, 1);
        @(negedge clk);
        chk(done == 1'b0, "R6 done not early", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R10 done cycle", done, 1);
        chk(busy == exp_busy, tag, busy, exp_busy);
        chk(total == 8'd100, "R3 R4 total", total, 100);
        chk(ctr_restart == 1'b1, "R6 restart raised", ctr_restart, 1);
        restart_ack = 1'b1;
        @(negedge clk); restart_ack = 1'b0;
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        chk(ctr_restart == 1'b0, "R6 restart released", ctr_restart, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && total == 0 && !done && !ctr_stop && !ctr_restart,
            "R1 in reset", {busy, total}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && total == 0 && !ctr_stop, "R1 after reset", {busy, total}, 0);

        // R2: enable loads timestamps and the initial pair
        time_ns = 64'd1_000_000_000;
        en = 1'b1;
        @(negedge clk);
        chk(busy == 8'd99, "R2 initial busy", busy, 99);
        chk(total == 8'd100, "R2 initial total", total, 100);

        // R3 R4 R5 table walk
        for (int i = 0; i < 8; i++) begin
            do_event(VEC[i][73:72], VEC[i][71:8], VEC[i][7:0],
                     $sformatf("R3 R4 R5 vector %0d busy", i));
        end

        // R7: two back-to-back events, acknowledge stalled
        @(negedge clk); ovf_flag = 2'b01; time_ns = 64'd5_000_000_000; ovf_evt = 1'b1;
        @(negedge clk);
        @(negedge clk); ovf_evt = 1'b0;
        chk(ctr_stop == 1'b1, "R7 first stop", ctr_stop, 1);
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1 && busy == 8'd35, "R7 first result", busy, 35);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk(ctr_restart == 1'b1 && ctr_stop == 1'b0, "R7 waiting for ack",
                {ctr_restart, ctr_stop}, 2);
        end
        restart_ack = 1'b1;
        @(negedge clk); restart_ack = 1'b0;
        @(negedge clk);
        chk(ctr_stop == 1'b1, "R7 queued stop", ctr_stop, 1);
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1 && busy == 8'd70, "R7 queued result", busy, 70);
        restart_ack = 1'b1;
        @(negedge clk); restart_ack = 1'b0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk(ctr_stop == 1'b0, "R7 no third event", ctr_stop, 0);
        end

        // R9: wrap of the time base
        en = 1'b0;
        repeat (2) @(negedge clk);
        time_ns = 64'hFFFF_FFFF_FFFF_FF9C;
        en = 1'b1;
        @(negedge clk);
        do_event(2'b01, 64'd50, 8'd70, "R9 wrap short interval");
        do_event(2'b10, 64'd899_999_900, 8'd35, "R9 wrap at threshold");

        // R8: events while disabled are ignored
        en = 1'b0;
        @(negedge clk); ovf_evt = 1'b1; ovf_flag = 2'b01;
        @(negedge clk); ovf_evt = 1'b0;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk(!ctr_stop && !done, "R8 disabled no activity", {ctr_stop, done}, 0);
        end
        en = 1'b1;
        @(negedge clk);
        chk(busy == 8'd99, "R8 re-enable pair", busy, 99);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk(!ctr_stop, "R8 nothing queued", ctr_stop, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule